// File: doc/BRIEF.md
# Column Instruction Sequencer

This block steps one column of a processing-element array, or a group of columns that share a loop kernel, through its instructions. It holds one program counter and broadcasts it to every element it serves. When several columns run the same kernel they are wired to a single instance, so they advance one shared count and follow the same branches. An `instrIssue` strobe marks the first cycle of each instruction. In that cycle the elements present their memory requests, and the sequencer prices them.

An instruction lasts at least one cycle. It ends only when three things hold: no element reports busy, the load phase has finished, and the store phase has finished. A phase that touches the column's memory bank costs two cycles plus one cycle per requesting element. Loads and stores are charged one after the other, so the two costs add. At the end of an instruction the sequencer does one of three things. It jumps to the branch target of the lowest-numbered element that requests a branch. If there is no branch and the counter sits on the configured exit instruction, it finishes the kernel. Otherwise it steps to the next instruction.

The column input pointer and output pointer are written while the block is idle. Each advances by one 32-bit word for every direct access made in an instruction. A host loads the configuration, pulses `start`, watches `running`, and receives a one-cycle `done` pulse.

Top module: `colSequencer`

## Requirements
- R1: After reset, `running`, `done`, `instrIssue`, `pc`, `inPtr` and `outPtr` are all 0.
- R2: While idle, `cfgLoad` copies `cfgInPtr`, `cfgOutPtr` and `cfgExitPc` into the block. While running, `cfgLoad` has no effect on `inPtr` or `outPtr`.
- R3: A `start` while idle makes `running` 1, `pc` 0 and `instrIssue` 1 in the next cycle. A `start` while running has no effect on `pc`.
- R4: An instruction lasts at least 1 cycle and ends in the first cycle in which no `peBusy` bit is set. `pc` holds throughout the instruction.
- R5: The memory cost of an instruction is c(L)+c(S), where L and S are the numbers of `peLoadReq` and `peStoreReq` bits sampled in its first cycle, and c(n) = 2+n for n>0 and c(0) = 0. The instruction lasts at least that many cycles.
- R6: When an instruction ends with no branch request and `pc` is not the exit instruction, `pc` increments by 1.
- R7: When an instruction ends with any `peBranchReq` bit set, `pc` takes the target of the lowest-numbered requester. Element i's target is `peBranchTarget[i*PC_W +: PC_W]`.
- R8: When the exit instruction ends with no branch request, `running` falls and `done` is 1 for exactly one cycle. A branch taken in the exit instruction keeps the kernel running.
- R9: At the end of an instruction, `inPtr` grows by 4 for each element with both `peLoadReq` and `peLoadDirect` set. `outPtr` grows by 4 for each element with both `peStoreReq` and `peStoreDirect` set. Both are sampled in the instruction's first cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgLoad | input | 1 | Write configuration (idle only) |
| cfgInPtr | input | ADDR_W | Initial input pointer |
| cfgOutPtr | input | ADDR_W | Initial output pointer |
| cfgExitPc | input | PC_W | Exit instruction index |
| start | input | 1 | Launch the kernel |
| peBusy | input | NUM_PE | Element still computing |
| peLoadReq | input | NUM_PE | Element loads this instruction |
| peLoadDirect | input | NUM_PE | Load uses the column input pointer |
| peStoreReq | input | NUM_PE | Element stores this instruction |
| peStoreDirect | input | NUM_PE | Store uses the column output pointer |
| peBranchReq | input | NUM_PE | Element requests a branch |
| peBranchTarget | input | NUM_PE*PC_W | Packed branch targets, element i at i*PC_W |
| pc | output | PC_W | Broadcast program counter |
| instrIssue | output | 1 | First cycle of an instruction |
| running | output | 1 | Kernel in progress |
| done | output | 1 | One-cycle kernel completion pulse |
| inPtr | output | ADDR_W | Column input pointer |
| outPtr | output | ADDR_W | Column output pointer |

## Verification
Two decisions can fall due in one ending cycle: a branch request and the exit test. The bench provokes this by raising a branch in the exit instruction itself. It then checks that `done` stays low, `running` stays high and `pc` lands on the winning target. A second coincidence occurs inside a single instruction. The stretch from a busy element overlaps the memory charge, and the instruction length must equal the larger of the two, not their sum. The bench provokes this with one load and a six-cycle busy element and expects seven cycles.

// File: rtl/colSeqPkg.sv
package colSeqPkg;
  typedef struct packed {
    logic launch;    // kernel starts, pc to zero
    logic capture;   // first cycle of instruction, latch request summary
    logic finish;    // last cycle of instruction
    logic cfgWrite;  // idle configuration write
  } seqStrobe_t;
endpackage

// File: rtl/colSeqCount.sv
module colSeqCount #(
  parameter int N = 4,
  parameter int W = 3
) (
  input  logic [N-1:0] bits,
  output logic [W-1:0] cnt
);
  always_comb begin
    cnt = '0;
    for (int i = 0; i < N; i++) cnt = cnt + W'(bits[i]);
  end
endmodule

// File: rtl/colSeqArbiter.sv
module colSeqArbiter #(
  parameter int NUM_PE = 4,
  parameter int PC_W   = 6
) (
  input  logic [NUM_PE-1:0]      req,
  input  logic [NUM_PE*PC_W-1:0] targets,
  output logic                   anyReq,
  output logic [PC_W-1:0]        target
);
  // scan from the top so the lowest-numbered requester is written last
  always_comb begin
    anyReq = |req;
    target = '0;
    for (int i = NUM_PE - 1; i >= 0; i--)
      if (req[i]) target = targets[i*PC_W +: PC_W];
  end
endmodule

// File: rtl/colSeqCtrl.sv
module colSeqCtrl
  import colSeqPkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             cfgLoad,
  input  logic             busyAny,
  input  logic [CNT_W-1:0] costEff,
  input  logic             atExit,
  output seqStrobe_t       strobe,
  output logic             running,
  output logic             done
);
  typedef enum logic {ST_IDLE, ST_RUN} seqState_t;

  seqState_t        state;
  logic             firstCyc;
  logic [CNT_W-1:0] cycleCnt;

  assign running = (state == ST_RUN);

  always_comb begin
    strobe.launch   = !running && start;
    strobe.cfgWrite = !running && cfgLoad;
    strobe.capture  = running && firstCyc;
    strobe.finish   = running && !busyAny && (cycleCnt >= costEff);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      firstCyc <= 1'b0;
      cycleCnt <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (strobe.launch) begin
        state    <= ST_RUN;
        firstCyc <= 1'b1;
        cycleCnt <= CNT_W'(1);
      end else if (strobe.finish) begin
        firstCyc <= 1'b1;
        cycleCnt <= CNT_W'(1);
        if (atExit) begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end
      end else if (running) begin
        firstCyc <= 1'b0;
        if (cycleCnt != '1) cycleCnt <= cycleCnt + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/colSeqData.sv
module colSeqData
  import colSeqPkg::*;
#(
  parameter int NUM_PE     = 4,
  parameter int PC_W       = 6,
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = 4,
  parameter int CNT_W      = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  seqStrobe_t             strobe,
  input  logic [ADDR_W-1:0]      cfgInPtr,
  input  logic [ADDR_W-1:0]      cfgOutPtr,
  input  logic [PC_W-1:0]        cfgExitPc,
  input  logic [NUM_PE-1:0]      peLoadReq,
  input  logic [NUM_PE-1:0]      peLoadDirect,
  input  logic [NUM_PE-1:0]      peStoreReq,
  input  logic [NUM_PE-1:0]      peStoreDirect,
  input  logic [NUM_PE-1:0]      peBranchReq,
  input  logic [NUM_PE*PC_W-1:0] peBranchTarget,
  output logic [PC_W-1:0]        pc,
  output logic [ADDR_W-1:0]      inPtr,
  output logic [ADDR_W-1:0]      outPtr,
  output logic [CNT_W-1:0]       costEff,
  output logic                   atExit
);
  localparam int POP_W    = $clog2(NUM_PE + 1);
  localparam int OVERHEAD = 2;

  logic [POP_W-1:0] ldCnt, stCnt, dlCnt, dsCnt;
  logic [POP_W-1:0] dlQ, dsQ, dlEff, dsEff;
  logic [CNT_W-1:0] costNow, costQ, ldCost, stCost;
  logic [PC_W-1:0]  exitPcQ, branchTgt;
  logic             branchAny;

  colSeqCount #(.N(NUM_PE), .W(POP_W)) i_ldCnt (.bits(peLoadReq), .cnt(ldCnt));
  colSeqCount #(.N(NUM_PE), .W(POP_W)) i_stCnt (.bits(peStoreReq), .cnt(stCnt));
  colSeqCount #(.N(NUM_PE), .W(POP_W)) i_dlCnt (.bits(peLoadReq & peLoadDirect), .cnt(dlCnt));
  colSeqCount #(.N(NUM_PE), .W(POP_W)) i_dsCnt (.bits(peStoreReq & peStoreDirect), .cnt(dsCnt));

  colSeqArbiter #(.NUM_PE(NUM_PE), .PC_W(PC_W)) i_arb (
    .req(peBranchReq), .targets(peBranchTarget), .anyReq(branchAny), .target(branchTgt)
  );

  always_comb begin
    ldCost  = (ldCnt != '0) ? CNT_W'(OVERHEAD) + CNT_W'(ldCnt) : '0;
    stCost  = (stCnt != '0) ? CNT_W'(OVERHEAD) + CNT_W'(stCnt) : '0;
    costNow = ldCost + stCost;
    costEff = strobe.capture ? costNow : costQ;
    dlEff   = strobe.capture ? dlCnt : dlQ;
    dsEff   = strobe.capture ? dsCnt : dsQ;
    atExit  = (pc == exitPcQ) && !branchAny;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pc      <= '0;
      inPtr   <= '0;
      outPtr  <= '0;
      exitPcQ <= '0;
      costQ   <= '0;
      dlQ     <= '0;
      dsQ     <= '0;
    end else begin
      if (strobe.cfgWrite) begin
        inPtr   <= cfgInPtr;
        outPtr  <= cfgOutPtr;
        exitPcQ <= cfgExitPc;
      end
      if (strobe.capture) begin
        costQ <= costNow;
        dlQ   <= dlCnt;
        dsQ   <= dsCnt;
      end
      if (strobe.launch) begin
        pc <= '0;
      end else if (strobe.finish) begin
        inPtr  <= inPtr + ADDR_W'(dlEff) * ADDR_W'(WORD_BYTES);
        outPtr <= outPtr + ADDR_W'(dsEff) * ADDR_W'(WORD_BYTES);
        if (branchAny)    pc <= branchTgt;
        else if (!atExit) pc <= pc + PC_W'(1);
      end
    end
  end
endmodule

// File: rtl/colSequencer.sv
module colSequencer
  import colSeqPkg::*;
#(
  parameter int NUM_PE = 4,
  parameter int PC_W   = 6,
  parameter int ADDR_W = 32
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cfgLoad,
  input  logic [ADDR_W-1:0]      cfgInPtr,
  input  logic [ADDR_W-1:0]      cfgOutPtr,
  input  logic [PC_W-1:0]        cfgExitPc,
  input  logic                   start,
  input  logic [NUM_PE-1:0]      peBusy,
  input  logic [NUM_PE-1:0]      peLoadReq,
  input  logic [NUM_PE-1:0]      peLoadDirect,
  input  logic [NUM_PE-1:0]      peStoreReq,
  input  logic [NUM_PE-1:0]      peStoreDirect,
  input  logic [NUM_PE-1:0]      peBranchReq,
  input  logic [NUM_PE*PC_W-1:0] peBranchTarget,
  output logic [PC_W-1:0]        pc,
  output logic                   instrIssue,
  output logic                   running,
  output logic                   done,
  output logic [ADDR_W-1:0]      inPtr,
  output logic [ADDR_W-1:0]      outPtr
);
  localparam int CNT_W = $clog2(2 * NUM_PE + 6);

  seqStrobe_t       strobe;
  logic [CNT_W-1:0] costEff;
  logic             atExit;

  colSeqCtrl #(.CNT_W(CNT_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .cfgLoad(cfgLoad),
    .busyAny(|peBusy), .costEff(costEff), .atExit(atExit),
    .strobe(strobe), .running(running), .done(done)
  );

  colSeqData #(.NUM_PE(NUM_PE), .PC_W(PC_W), .ADDR_W(ADDR_W), .WORD_BYTES(4), .CNT_W(CNT_W)) i_data (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .cfgInPtr(cfgInPtr), .cfgOutPtr(cfgOutPtr), .cfgExitPc(cfgExitPc),
    .peLoadReq(peLoadReq), .peLoadDirect(peLoadDirect),
    .peStoreReq(peStoreReq), .peStoreDirect(peStoreDirect),
    .peBranchReq(peBranchReq), .peBranchTarget(peBranchTarget),
    .pc(pc), .inPtr(inPtr), .outPtr(outPtr), .costEff(costEff), .atExit(atExit)
  );

  assign instrIssue = strobe.capture;
endmodule

// File: rtl/colSequencerChk.sv
module colSequencerChk #(
  parameter int PC_W   = 6,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              cfgLoad,
  input logic [PC_W-1:0]   pc,
  input logic              instrIssue,
  input logic              running,
  input logic              done,
  input logic [ADDR_W-1:0] inPtr,
  input logic [ADDR_W-1:0] outPtr
);
  p_issue_running_r3: assert property (@(posedge clk) disable iff (!rstN)
    instrIssue |-> running);

  p_pc_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (running && !instrIssue) |-> $stable(pc));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !running);

  p_ptr_mid_r9: assert property (@(posedge clk) disable iff (!rstN)
    (running && !instrIssue) |-> ($stable(inPtr) && $stable(outPtr)));

  p_ptr_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!running && !$past(running) && !$past(cfgLoad)) |-> ($stable(inPtr) && $stable(outPtr)));
endmodule

bind colSequencer colSequencerChk #(.PC_W(PC_W), .ADDR_W(ADDR_W)) i_chk (.*);

// File: tb/test_colSequencer.sv
`timescale 1ns/1ps
module test_colSequencer;
  localparam int NUM_PE = 4;
  localparam int PC_W   = 6;
  localparam int ADDR_W = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgLoad = 1'b0;
  logic [ADDR_W-1:0] cfgInPtr = '0, cfgOutPtr = '0;
  logic [PC_W-1:0] cfgExitPc = '0;
  logic start = 1'b0;
  logic [NUM_PE-1:0] peBusy = '0, peLoadReq = '0, peLoadDirect = '0;
  logic [NUM_PE-1:0] peStoreReq = '0, peStoreDirect = '0, peBranchReq = '0;
  logic [NUM_PE*PC_W-1:0] peBranchTarget = '0;
  logic [PC_W-1:0] pc;
  logic instrIssue, running, done;
  logic [ADDR_W-1:0] inPtr, outPtr;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  colSequencer #(.NUM_PE(NUM_PE), .PC_W(PC_W), .ADDR_W(ADDR_W)) i_colSequencer (.*);

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [NUM_PE*PC_W-1:0] tgts(input int t0, input int t1, input int t2, input int t3);
    logic [NUM_PE*PC_W-1:0] v;
    v = {PC_W'(t3), PC_W'(t2), PC_W'(t1), PC_W'(t0)};
    return v;
  endfunction

  task automatic configure(input logic [ADDR_W-1:0] ip, input logic [ADDR_W-1:0] op, input int ex);
    @(negedge clk);
    cfgLoad = 1'b1; cfgInPtr = ip; cfgOutPtr = op; cfgExitPc = PC_W'(ex);
    @(negedge clk);
    cfgLoad = 1'b0;
    check(inPtr == ip, "R2 inPtr load", inPtr, ip);
    check(outPtr == op, "R2 outPtr load", outPtr, op);
  endtask

  task automatic launch();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(running && instrIssue && pc == 0, "R3 launch", {running, instrIssue, pc}, {2'b11, 6'd0});
  endtask

  // runs one instruction starting at a negedge where instrIssue is high
  task automatic runInstr(input int expPc, input logic [3:0] ld, input logic [3:0] ldDir,
                          input logic [3:0] st, input logic [3:0] stDir, input int busyCyc,
                          input logic [3:0] br, input logic [NUM_PE*PC_W-1:0] tg,
                          input int expLen, input string req);
    int n;
    check(instrIssue && pc == PC_W'(expPc), req, pc, expPc);
    peLoadReq = ld; peLoadDirect = ldDir; peStoreReq = st; peStoreDirect = stDir;
    peBranchReq = br; peBranchTarget = tg;
    peBusy = {3'b000, busyCyc >= 1};
    n = 1;
    forever begin
      @(posedge clk);
      @(negedge clk);
      if (instrIssue || !running) break;
      n++;
      peBusy = {3'b000, n <= busyCyc};
      if (n > 100) break;
    end
    check(n == expLen, req, n, expLen);
    peLoadReq = '0; peLoadDirect = '0; peStoreReq = '0; peStoreDirect = '0;
    peBranchReq = '0; peBusy = '0;
  endtask

  task automatic expectDone(input string req);
    check(done && !running, req, {done, running}, 2'b10);
    @(negedge clk);
    check(!done, req, done, 0);
  endtask

  task automatic testReset();
    check(!running && !done && !instrIssue && pc == 0 && inPtr == 0 && outPtr == 0,
          "R1 reset state", {running, done, instrIssue, pc}, 0);
  endtask

  task automatic testSequence();
    configure(32'h1000, 32'h2000, 3);
    launch();
    for (int p = 0; p < 4; p++) runInstr(p, 0, 0, 0, 0, 0, 0, 0, 1, "R6 step length 1");
    expectDone("R8 done pulse");
  endtask

  task automatic testTiming();
    launch();
    runInstr(0, 4'b0000, 0, 4'b0000, 0, 3, 0, 0, 4, "R4 busy extends");
    runInstr(1, 4'b0011, 0, 4'b0000, 0, 0, 0, 0, 4, "R5 two loads");
    runInstr(2, 4'b0011, 0, 4'b0111, 0, 0, 0, 0, 9, "R5 loads plus stores");
    runInstr(3, 4'b0001, 0, 4'b0000, 0, 6, 0, 0, 7, "R4 R5 busy over memory");
    expectDone("R8 done after timing kernel");
  endtask

  task automatic testPointers();
    configure(32'h1000, 32'h2000, 3);
    launch();
    runInstr(0, 4'b0111, 4'b0111, 0, 0, 0, 0, 0, 5, "R5 three loads");
    check(inPtr == 32'h100C, "R9 inPtr advance", inPtr, 32'h100C);
    runInstr(1, 4'b0010, 4'b0000, 4'b1001, 4'b1001, 0, 0, 0, 7, "R5 mixed");
    check(outPtr == 32'h2008, "R9 outPtr advance", outPtr, 32'h2008);
    check(inPtr == 32'h100C, "R9 indirect load no move", inPtr, 32'h100C);
    cfgLoad = 1'b1; cfgInPtr = 32'h5000; cfgOutPtr = 32'h6000;
    runInstr(2, 0, 0, 0, 0, 0, 0, 0, 1, "R6 pc2");
    cfgLoad = 1'b0;
    check(inPtr == 32'h100C && outPtr == 32'h2008, "R2 cfg ignored running", inPtr, 32'h100C);
    runInstr(3, 0, 0, 0, 0, 0, 0, 0, 1, "R6 pc3");
    expectDone("R8 done after pointer kernel");
  endtask

  task automatic testBranch();
    launch();
    runInstr(0, 0, 0, 0, 0, 0, 4'b1010, tgts(0, 2, 0, 0), 1, "R7 branch issue");
    runInstr(2, 0, 0, 0, 0, 0, 0, 0, 1, "R7 lowest requester wins");
    runInstr(3, 0, 0, 0, 0, 0, 4'b0100, tgts(0, 0, 1, 0), 1, "R8 exit instr");
    check(!done && running, "R8 branch at exit keeps running", {done, running}, 2'b01);
    start = 1'b1;
    runInstr(1, 0, 0, 0, 0, 0, 0, 0, 1, "R7 exit branch target");
    start = 1'b0;
    runInstr(2, 0, 0, 0, 0, 0, 0, 0, 1, "R3 start ignored running");
    runInstr(3, 0, 0, 0, 0, 0, 0, 0, 1, "R6 to exit");
    expectDone("R8 done after branch kernel");
  endtask

  initial begin
    #(200000 * 5.0);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testSequence();
    testTiming();
    testPointers();
    testBranch();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule